// File: doc/BRIEF.md
# Programmable Clock Output Stage

This block is one output channel of a clock distributor. Six candidate clocks arrive as single-cycle enable pulses in the system clock domain: four synthesizer clocks (A to D), the fast reference and the 32 kHz reference. Each pulse stands for one rising edge of that clock. A 2-bit source code picks which candidate drives the channel. The mapping from code to candidate depends on the channel number, which is set by a parameter. The channel divides the chosen clock by an 8-bit value, can invert the result, and then applies an output-enable bit and a power-down bit. Together these make the pin active, tri-stated or driven low.

Three register sets are held outside the block and presented to it in parallel. A pair of select pins picks one of the three sets, or a sleep state. In sleep, every channel is driven low, with one exception: when the keep-alive bit is set, channel 4 keeps forwarding the 32 kHz reference. A slew-rate field passes straight through from the selected set. A change of register set takes effect only when the divider wraps, so no shortened period appears on the pin. An idle channel, or a request for sleep, applies its settings at the next clock.

Top module: `clkout_stage`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `clk_o` is 0 and `drv_o` is 1.
- R2: For channel 0, source codes 1, 2 and 3 select pulse bits 1 (synth B), 2 (synth C) and 3 (synth D). For channel 4 they select bits 0 (synth A), 2 (synth C) and 4 (fast reference). Bit 5 is the 32 kHz reference. Pulses on bits that are not selected have no effect on `clk_o`.
- R3: Source code 0 stops the channel: `clk_o` stays 0 whatever pulses arrive, and `drv_o` follows the enable and power-down bits.
- R4: For a divide value N of 2 or more, counting selected pulses k = 1, 2, ... after the channel starts, `clk_o` after pulse k is 1 exactly when (k mod N) < ceil(N/2). The level holds between pulses.
- R5: For a divide value of 0 or 1, `clk_o` is 1 in the cycle after each selected pulse and 0 otherwise.
- R6: An invert bit of 1 flips `clk_o` while the channel is running and driven. This includes the level 1 seen before the first pulse.
- R7: A power-down bit of 0 gives `drv_o` = 1 and `clk_o` = 0, whatever the enable bit.
- R8: An enable bit of 0 with the power-down bit at 1 gives `drv_o` = 0 (tri-state) and `clk_o` = 0.
- R9: Select pins 01, 10 and 11 choose register sets 0, 1 and 2.
- R10: Select pins 00 choose sleep, which takes effect at the next clock. With keep-alive 0, every channel has `drv_o` = 1 and `clk_o` = 0. With keep-alive 1, channel 4 acts as a divide-by-1 of bit 5, and the other channels stay driven low.
- R11: While a source is running, a new register set or a new field value loads only on the selected pulse that wraps the divider. The outputs hold until then. A channel with source code 0 loads on the next clock.
- R12: `slew_o` equals the slew field of the selected set, and is 0 in sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 6 | Edge pulses: A, B, C, D, fast reference, 32 kHz reference (bit 0 to bit 5) |
| sel | input | 2 | Register set / sleep select pins |
| keep_slow | input | 1 | In sleep, keep the 32 kHz clock on channel 4 |
| cfg_src | input | 6 | Source code, 2 bits per set |
| cfg_div | input | 24 | Divide value, 8 bits per set |
| cfg_inv | input | 3 | Invert bit per set |
| cfg_oe | input | 3 | Output enable bit per set |
| cfg_pdb | input | 3 | Power-down bit per set, active low |
| cfg_slew | input | 6 | Slew field, 2 bits per set |
| clk_o | output | 1 | Clock level toward the pad |
| drv_o | output | 1 | Pad drive enable; 0 means tri-state |
| slew_o | output | 2 | Slew field of the selected set |

## Verification
The divided level and the drive enable come from registers that update on the clock edge where a pulse or a set change is sampled. Every check therefore samples at the falling edge that follows that rising edge, one cycle after the stimulus. The slew field is combinational and is checked in the same half cycle in which the select pins change. Held values, during a pending set change or between pulses, are sampled again after extra idle cycles. This confirms that nothing moves until the wrapping pulse.

// File: rtl/clkout_stage.sv
module clkout_stage #(
  parameter int OUT_ID = 0,
  parameter int DIV_W  = 8,
  parameter int NCFG   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [5:0]              src_tick,
  input  logic [1:0]              sel,
  input  logic                    keep_slow,
  input  logic [2*NCFG-1:0]       cfg_src,
  input  logic [DIV_W*NCFG-1:0]   cfg_div,
  input  logic [NCFG-1:0]         cfg_inv,
  input  logic [NCFG-1:0]         cfg_oe,
  input  logic [NCFG-1:0]         cfg_pdb,
  input  logic [2*NCFG-1:0]       cfg_slew,
  output logic                    clk_o,
  output logic                    drv_o,
  output logic [1:0]              slew_o
);
  localparam logic [2:0] NONE = 3'd7;
  localparam logic [2:0] SLOW = 3'd5;
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  function automatic logic [2:0] map_src(input logic [1:0] code);
    logic [2:0] r;
    r = NONE;
    case (OUT_ID)
      1:       case (code) 2'd1: r = 3'd5; 2'd2: r = 3'd1; 2'd3: r = 3'd3; default: r = NONE; endcase
      2:       case (code) 2'd1: r = 3'd2; 2'd2: r = 3'd4; 2'd3: r = 3'd5; default: r = NONE; endcase
      3:       case (code) 2'd1: r = 3'd2; 2'd2: r = 3'd0; 2'd3: r = 3'd1; default: r = NONE; endcase
      4:       case (code) 2'd1: r = 3'd0; 2'd2: r = 3'd2; 2'd3: r = 3'd4; default: r = NONE; endcase
      default: case (code) 2'd1: r = 3'd1; 2'd2: r = 3'd2; 2'd3: r = 3'd3; default: r = NONE; endcase
    endcase
    return r;
  endfunction

  logic             sleep;
  logic [1:0]       idx;
  logic [DIV_W-1:0] sel_div;
  logic [2:0]       nxt_psrc;
  logic [DIV_W-1:0] nxt_n;
  logic             nxt_inv, nxt_oe, nxt_pdb;

  assign sleep   = (sel == 2'b00);
  assign idx     = sleep ? 2'd0 : sel - 2'd1;
  assign sel_div = cfg_div[int'(idx)*DIV_W +: DIV_W];
  assign slew_o  = sleep ? 2'b00 : cfg_slew[int'(idx)*2 +: 2];

  always_comb begin
    if (sleep) begin
      nxt_psrc = (keep_slow && OUT_ID == 4) ? SLOW : NONE;
      nxt_n    = ONE;
      nxt_inv  = 1'b0;
      nxt_oe   = 1'b1;
      nxt_pdb  = keep_slow && OUT_ID == 4;
    end else begin
      nxt_psrc = map_src(cfg_src[int'(idx)*2 +: 2]);
      nxt_n    = (sel_div == '0) ? ONE : sel_div;
      nxt_inv  = cfg_inv[idx];
      nxt_oe   = cfg_oe[idx];
      nxt_pdb  = cfg_pdb[idx];
    end
  end

  logic [2:0]       act_psrc;
  logic [DIV_W-1:0] act_n;
  logic             act_inv, act_oe, act_pdb;
  logic [DIV_W-1:0] cnt;
  logic             q;

  logic             running, tick, term, load;
  logic [DIV_W-1:0] cnt_nx;
  logic [DIV_W:0]   hi_len;
  logic [7:0]       tick_pad;

  assign tick_pad = {2'b00, src_tick};
  assign running  = (act_psrc != NONE);
  assign tick     = running && tick_pad[act_psrc];
  assign term     = tick && (cnt >= act_n - ONE);
  assign load     = !running || term || sleep;
  assign cnt_nx   = term ? '0 : cnt + ONE;
  assign hi_len   = ({1'b0, act_n} + 1'b1) >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_psrc <= NONE;
      act_n    <= ONE;
      act_inv  <= 1'b0;
      act_oe   <= 1'b1;
      act_pdb  <= 1'b0;
    end else if (load) begin
      act_psrc <= nxt_psrc;
      act_n    <= nxt_n;
      act_inv  <= nxt_inv;
      act_oe   <= nxt_oe;
      act_pdb  <= nxt_pdb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      q   <= 1'b0;
    end else if (!running) begin
      cnt <= '0;
      q   <= 1'b0;
    end else if (act_n == ONE) begin
      cnt <= '0;
      q   <= tick;
    end else if (tick) begin
      cnt <= cnt_nx;
      q   <= ({1'b0, cnt_nx} < hi_len);
    end
  end

  assign clk_o = act_pdb && act_oe && running && (q ^ act_inv);
  assign drv_o = !act_pdb || act_oe;
endmodule

// File: rtl/clkout_stage_chk.sv
module clkout_stage_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] src_tick,
  input logic [1:0] sel,
  input logic       keep_slow,
  input logic       clk_o,
  input logic       drv_o,
  input logic       running
);
  logic prev_any;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_any <= 1'b0;
    else        prev_any <= |src_tick;

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!clk_o && drv_o));

  // R8
  tri_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_o |-> !clk_o);

  // R10
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b00 && !keep_slow) |=> (!clk_o && drv_o));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && src_tick == 6'd0 && !prev_any && sel != 2'b00)
      |=> ($stable(clk_o) && $stable(drv_o)));
endmodule

bind clkout_stage clkout_stage_chk u_chk (
  .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .sel(sel),
  .keep_slow(keep_slow), .clk_o(clk_o), .drv_o(drv_o), .running(running)
);

// File: tb/sim_clkout_stage.sv
module sim_clkout_stage;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0]  src_tick = '0;
  logic [1:0]  sel = 2'b01;
  logic        keep_slow = 1'b0;
  logic [5:0]  cfg_src = '0;
  logic [23:0] cfg_div = '0;
  logic [2:0]  cfg_inv = '0, cfg_oe = 3'b111, cfg_pdb = 3'b111;
  logic [5:0]  cfg_slew = '0;
  logic clk0, drv0, clk4, drv4;
  logic [1:0] slew0, slew4;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkout_stage #(.OUT_ID(0)) u0 (.clk, .rst_n, .src_tick, .sel, .keep_slow, .cfg_src, .cfg_div,
    .cfg_inv, .cfg_oe, .cfg_pdb, .cfg_slew, .clk_o(clk0), .drv_o(drv0), .slew_o(slew0));
  clkout_stage #(.OUT_ID(4)) u4 (.clk, .rst_n, .src_tick, .sel, .keep_slow, .cfg_src, .cfg_div,
    .cfg_inv, .cfg_oe, .cfg_pdb, .cfg_slew, .clk_o(clk4), .drv_o(drv4), .slew_o(slew4));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [5:0] b);
    src_tick = b;
    @(negedge clk);
    src_tick = '0;
  endtask

  function automatic int divexp(input int k, input int n);
    int nn = (n == 0) ? 1 : n;
    if (nn == 1) return 1;
    return ((k % nn) < (nn + 1) / 2) ? 1 : 0;
  endfunction

  task automatic restart();
    sel = 2'b00; idle(2);
    sel = 2'b01; idle(2);
  endtask

  task automatic cfg0(input int code, input int dv, input bit inv, input bit oe, input bit pdb);
    cfg_src[1:0] = 2'(code); cfg_div[7:0] = 8'(dv);
    cfg_inv[0] = inv; cfg_oe[0] = oe; cfg_pdb[0] = pdb;
    restart();
  endtask

  task automatic t_reset();
    idle(2);
    chk("R1 clk in reset", clk0, 0); chk("R1 drv in reset", drv0, 1);
    rst_n = 1'b1; idle(1);
    chk("R1 clk after release", clk0, 0); chk("R1 drv after release", drv0, 1);
  endtask

  task automatic t_map();
    int m4[4] = '{7, 0, 2, 4};
    for (int c = 1; c <= 3; c++) begin
      cfg0(c, 1, 0, 1, 1);
      for (int b = 0; b < 6; b++) begin
        pulse(6'(1 << b));
        chk($sformatf("R2 out0 code%0d bit%0d", c, b), clk0, (b == c) ? 1 : 0);
        chk($sformatf("R2 out4 code%0d bit%0d", c, b), clk4, (b == m4[c]) ? 1 : 0);
        idle(1);
      end
    end
  endtask

  task automatic t_off();
    cfg0(0, 1, 0, 1, 1);
    for (int b = 0; b < 6; b++) begin
      pulse(6'(1 << b));
      chk("R3 off clk", clk0, 0); chk("R3 off drv", drv0, 1);
    end
  endtask

  task automatic t_div(input int n, input bit inv);
    cfg0(1, n, inv, 1, 1);
    chk("R6 level before first pulse", clk0, inv ? 1 : 0);
    for (int k = 1; k <= 3 * ((n == 0) ? 1 : n) + 2; k++) begin
      pulse(6'b000010);
      chk($sformatf("R4/R5/R6 div%0d k%0d", n, k), clk0, divexp(k, n) ^ int'(inv));
      idle(2);
      chk($sformatf("R4/R5 hold div%0d k%0d", n, k), clk0,
          ((n <= 1) ? 0 : divexp(k, n)) ^ int'(inv));
    end
  endtask

  task automatic t_drive();
    for (int oe = 0; oe < 2; oe++) begin
      cfg0(1, 2, 1, oe[0], 0);
      for (int k = 0; k < 3; k++) begin
        pulse(6'b000010);
        chk("R7 pd clk", clk0, 0); chk("R7 pd drv", drv0, 1);
      end
    end
    cfg0(1, 2, 1, 0, 1);
    for (int k = 0; k < 3; k++) begin
      pulse(6'b000010);
      chk("R8 tri clk", clk0, 0); chk("R8 tri drv", drv0, 0);
    end
  endtask

  task automatic t_sets();
    cfg_slew = 6'b11_10_01;
    cfg_src[3:2] = 2'd0; cfg_oe[1] = 1'b0; cfg_pdb[1] = 1'b1;
    cfg_src[5:4] = 2'd0; cfg_oe[2] = 1'b1; cfg_pdb[2] = 1'b0;
    cfg0(1, 1, 1, 1, 1);
    chk("R9 set0 clk", clk0, 1); chk("R9 set0 drv", drv0, 1);
    chk("R12 slew set0", slew0, 1);
    sel = 2'b10; #1;
    chk("R12 slew set1", slew0, 2);
    idle(3);
    chk("R11 pending clk", clk0, 1); chk("R11 pending drv", drv0, 1);
    pulse(6'b000010);
    chk("R9 set1 clk", clk0, 0); chk("R9 set1 drv", drv0, 0);
    sel = 2'b11; #1;
    chk("R12 slew set2", slew0, 3);
    idle(2);
    chk("R9 set2 clk", clk0, 0); chk("R9 set2 drv", drv0, 1);
    sel = 2'b00; #1;
    chk("R12 slew sleep", slew4, 0);
    cfg_slew = '0;
  endtask

  task automatic t_midchange();
    cfg0(1, 4, 0, 1, 1);
    pulse(6'b000010); pulse(6'b000010);
    cfg_div[7:0] = 8'd2;
    idle(2);
    chk("R11 hold before wrap", clk0, 0);
    for (int k = 3; k <= 6; k++) begin
      pulse(6'b000010);
      chk($sformatf("R11 wrap load k%0d", k), clk0, (k % 2 == 0) ? 1 : 0);
    end
  endtask

  task automatic t_sleep();
    cfg0(0, 1, 0, 1, 1);
    keep_slow = 1'b1; sel = 2'b00; idle(2);
    pulse(6'b100010);
    chk("R10 keep out4 clk", clk4, 1); chk("R10 keep out4 drv", drv4, 1);
    chk("R10 keep out0 clk", clk0, 0); chk("R10 keep out0 drv", drv0, 1);
    idle(1);
    chk("R10 keep out4 low", clk4, 0);
    keep_slow = 1'b0; idle(2);
    pulse(6'b100000);
    chk("R10 off out4 clk", clk4, 0); chk("R10 off out4 drv", drv4, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_map();
    t_off();
    t_div(4, 0);
    t_div(5, 0);
    t_div(0, 0);
    t_div(4, 1);
    t_drive();
    t_sets();
    t_midchange();
    t_sleep();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule